// File: doc/BRIEF.md
# SPI Interrupt Source Controller

This block turns the condition of an SPI controller's transmit and receive FIFOs, together with its end-of-operation event, into five interrupt sources and one combined interrupt line. Four sources are status conditions that track the FIFOs cycle by cycle. These are transmit FIFO empty, receive FIFO full, transmit level at or under a programmable mark, and receive level at or over a programmable mark. The fifth source is an event: it latches when an operation completes and stays set until software acknowledges it.

Software reaches the block through a single-cycle write port that selects one of three registers. The state register takes acknowledgements, where writing 1 to a bit clears it. The enable register masks each source. The test register forces sources for checking interrupt wiring. The state and enable registers are brought out as ports so that the surrounding register file can read them. The FIFOs and the serial engine sit outside this block.

Top module: `spi_irq_ctrl`

## Requirements
- R1: While `rst` is high, `state_o`, `enable_o` and `irq_o` are all zero.
- R2: The state bit positions are fixed: bit 0 is receive full, bit 1 is receive mark, bit 2 is transmit empty, bit 3 is transmit mark, and bit 4 is completion. Each bit reflects the cycle before the clock edge that updates it.
- R3: State bit 3 is 1 one cycle after a cycle in which `tx_level_i` is less than or equal to the zero-extended `tx_mark_i`, and is 0 otherwise.
- R4: State bit 1 is 1 one cycle after a cycle in which `rx_level_i` is greater than or equal to the zero-extended `rx_mark_i`, and is 0 otherwise.
- R5: State bits 0 and 2 copy `rx_full_i` and `tx_empty_i` with one cycle of delay. Writing 1 to these bits through the state register has no effect.
- R6: A cycle with `done_i` high sets state bit 4 on the next cycle.
- R7: State bit 4 stays set until a state write (`wr_sel_i` = 0) carries a 1 in bit 4. Writing 0 leaves it set. If `done_i` is high in the same cycle as that write, the bit stays set.
- R8: A write with `wr_sel_i` = 1 loads `wr_data_i` into `enable_o` on the next cycle.
- R9: A write with `wr_sel_i` = 2 forces the state bits where `wr_data_i` is 1. Status bits are forced for that one update only, and bit 4 latches as if a completion had occurred.
- R10: `irq_o` is registered and always equals the OR of `state_o & enable_o`, so it changes in the same cycle as the state and enable values it depends on.
- R11: A write with `wr_sel_i` = 3 changes neither `state_o` nor `enable_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| rx_full_i | input | 1 | Receive FIFO full flag |
| tx_mark_i | input | MARK_W | Transmit low-water mark |
| rx_mark_i | input | MARK_W | Receive high-water mark |
| done_i | input | 1 | One-cycle pulse at the end of an operation |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 state, 1 enable, 2 test, 3 unused |
| wr_data_i | input | 5 | Write data, one bit per source |
| state_o | output | 5 | Interrupt state register |
| enable_o | output | 5 | Interrupt enable register |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach is a completion pulse that arrives in the same cycle as the acknowledgement that would clear the completion bit. The stimulus drives `done_i` while a state write with bit 4 set is in flight, then checks that the bit survives. Mark comparisons are also exercised where the FIFO level exceeds anything the 4-bit mark can express. Beyond these directed cases, a long stretch of random levels, flags, pulses and writes is compared against the reference model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC = 5;

  localparam int BIT_RX_FULL = 0;
  localparam int BIT_RX_MARK = 1;
  localparam int BIT_TX_EMPTY = 2;
  localparam int BIT_TX_MARK = 3;
  localparam int BIT_DONE = 4;

  localparam logic [NUM_SRC-1:0] EVENT_MASK = 5'b10000;

  localparam logic [1:0] SEL_STATE = 2'd0;
  localparam logic [1:0] SEL_ENABLE = 2'd1;
  localparam logic [1:0] SEL_TEST = 2'd2;
endpackage

// File: rtl/irqc_src_detect.sv
module irqc_src_detect
  import irqc_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int MARK_W = 4
) (
  input  logic [LVL_W-1:0]   tx_level_i,
  input  logic [LVL_W-1:0]   rx_level_i,
  input  logic               tx_empty_i,
  input  logic               rx_full_i,
  input  logic [MARK_W-1:0]  tx_mark_i,
  input  logic [MARK_W-1:0]  rx_mark_i,
  input  logic               done_i,
  output logic [NUM_SRC-1:0] raw_o
);
  localparam int CMP_W = (LVL_W > MARK_W) ? LVL_W : MARK_W;

  logic [CMP_W-1:0] tx_lvl_x, rx_lvl_x, tx_mark_x, rx_mark_x;

  assign tx_lvl_x = CMP_W'(tx_level_i);
  assign rx_lvl_x = CMP_W'(rx_level_i);
  assign tx_mark_x = CMP_W'(tx_mark_i);
  assign rx_mark_x = CMP_W'(rx_mark_i);

  always_comb begin
    raw_o = '0;
    raw_o[BIT_RX_FULL] = rx_full_i;
    raw_o[BIT_RX_MARK] = (rx_lvl_x >= rx_mark_x);
    raw_o[BIT_TX_EMPTY] = tx_empty_i;
    raw_o[BIT_TX_MARK] = (tx_lvl_x <= tx_mark_x);
    raw_o[BIT_DONE] = done_i;
  end
endmodule

// File: rtl/irqc_cell.sv
module irqc_cell #(
  parameter bit IS_EVENT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic force_i,
  input  logic ack_i,
  output logic d_o,
  output logic q_o
);
  generate
    if (IS_EVENT) begin : g_event
      assign d_o = raw_i | force_i | (q_o & ~ack_i);
    end else begin : g_level
      assign d_o = raw_i | force_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int MARK_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   tx_level_i,
  input  logic [LVL_W-1:0]   rx_level_i,
  input  logic               tx_empty_i,
  input  logic               rx_full_i,
  input  logic [MARK_W-1:0]  tx_mark_i,
  input  logic [MARK_W-1:0]  rx_mark_i,
  input  logic               done_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] state_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic               irq_o
);
  logic               wr_state, wr_enable, wr_test;
  logic [NUM_SRC-1:0] raw, st_d, st_q, en_d, en_q;
  logic               irq_q;

  assign wr_state = wr_en_i && (wr_sel_i == SEL_STATE);
  assign wr_enable = wr_en_i && (wr_sel_i == SEL_ENABLE);
  assign wr_test = wr_en_i && (wr_sel_i == SEL_TEST);

  irqc_src_detect #(.LVL_W(LVL_W), .MARK_W(MARK_W)) u_detect (
    .tx_level_i(tx_level_i),
    .rx_level_i(rx_level_i),
    .tx_empty_i(tx_empty_i),
    .rx_full_i (rx_full_i),
    .tx_mark_i (tx_mark_i),
    .rx_mark_i (rx_mark_i),
    .done_i    (done_i),
    .raw_o     (raw)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      irqc_cell #(.IS_EVENT(EVENT_MASK[i])) u_cell (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw[i]),
        .force_i(wr_test & wr_data_i[i]),
        .ack_i  (wr_state & wr_data_i[i]),
        .d_o    (st_d[i]),
        .q_o    (st_q[i])
      );
    end
  endgenerate

  assign en_d = wr_enable ? wr_data_i : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q <= en_d;
      irq_q <= |(st_d & en_d);
    end
  end

  assign state_o = st_q;
  assign enable_o = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int MARK_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [LVL_W-1:0]   tx_level_i,
  input logic [LVL_W-1:0]   rx_level_i,
  input logic               tx_empty_i,
  input logic [MARK_W-1:0]  tx_mark_i,
  input logic [MARK_W-1:0]  rx_mark_i,
  input logic               done_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_sel_i,
  input logic [NUM_SRC-1:0] wr_data_i,
  input logic [NUM_SRC-1:0] state_o,
  input logic [NUM_SRC-1:0] enable_o,
  input logic               irq_o
);
  logic ack_done, force_empty;
  assign ack_done = wr_en_i && wr_sel_i == 2'd0 && wr_data_i[BIT_DONE];
  assign force_empty = wr_en_i && wr_sel_i == 2'd2 && wr_data_i[BIT_TX_EMPTY];

  AST_TX_MARK_SET: assert property (@(posedge clk) disable iff (rst)
    ({{32{1'b0}}, tx_level_i} <= {{32{1'b0}}, tx_mark_i}) |=> state_o[BIT_TX_MARK]); // R3
  AST_RX_MARK_SET: assert property (@(posedge clk) disable iff (rst)
    ({{32{1'b0}}, rx_level_i} >= {{32{1'b0}}, rx_mark_i}) |=> state_o[BIT_RX_MARK]); // R4
  AST_EMPTY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty_i && !force_empty) |=> !state_o[BIT_TX_EMPTY]); // R5
  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
    done_i |=> state_o[BIT_DONE]); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_o[BIT_DONE] && !ack_done) |=> state_o[BIT_DONE]); // R7
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == 2'd1) |=> (enable_o == $past(wr_data_i))); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(state_o & enable_o)); // R10
endmodule

bind spi_irq_ctrl irqc_checker #(.LVL_W(LVL_W), .MARK_W(MARK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_level_i(tx_level_i),
  .rx_level_i(rx_level_i),
  .tx_empty_i(tx_empty_i),
  .tx_mark_i (tx_mark_i),
  .rx_mark_i (rx_mark_i),
  .done_i    (done_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .state_o   (state_o),
  .enable_o  (enable_o),
  .irq_o     (irq_o)
);

// File: tb/sim_spi_irq_ctrl.sv
module sim_spi_irq_ctrl;
  localparam int LW = 8;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] tx_level = 8, rx_level = 0;
  logic          tx_empty = 0, rx_full = 0, done = 0, wr_en = 0;
  logic [MW-1:0] tx_mark = 2, rx_mark = 4;
  logic [1:0]    wr_sel = 0;
  logic [4:0]    wr_data = 0;
  logic [4:0]    state, enable;
  logic          irq;

  int checks = 0, errors = 0, cycles = 0;
  int ms = 0, me = 0, mi = 0;

  always #10 clk = ~clk;

  spi_irq_ctrl #(.LVL_W(LW), .MARK_W(MW)) u0 (
    .clk(clk), .rst(rst), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_empty_i(tx_empty), .rx_full_i(rx_full), .tx_mark_i(tx_mark),
    .rx_mark_i(rx_mark), .done_i(done), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .state_o(state), .enable_o(enable), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model: behaviour of the requirements, updated at each edge
  always @(posedge clk) begin
    int ack, frc, nxt;
    if (rst) begin
      ms = 0; me = 0; mi = 0;
    end else begin
      ack = (wr_en && wr_sel == 0) ? int'(wr_data) : 0;
      frc = (wr_en && wr_sel == 2) ? int'(wr_data) : 0;
      if (wr_en && wr_sel == 1) me = int'(wr_data);
      nxt = 0;
      if (rx_full) nxt += 1;
      if (int'(rx_level) >= int'(rx_mark)) nxt += 2;
      if (tx_empty) nxt += 4;
      if (int'(tx_level) <= int'(tx_mark)) nxt += 8;
      if (done || ((ms & 16) != 0 && (ack & 16) == 0)) nxt += 16;
      ms = nxt | frc;
      mi = ((ms & me) != 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R10 model state", int'(state), ms);
    chk("R10 model enable", int'(enable), me);
    chk("R10 model irq", int'(irq), mi);
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 5000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [4:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    cyc(); cyc(); cyc();
    chk("R1 state", int'(state), 0);
    chk("R1 enable", int'(enable), 0);
    chk("R1 irq", int'(irq), 0);
    rst = 0;
    cyc();
    chk("R1 idle state", int'(state), 0);

    tx_level = 3; tx_mark = 3; cyc();
    chk("R3 equal", int'(state), 5'b01000);
    chk("R2 tx mark bit", int'(state[3]), 1);
    tx_level = 4; cyc();
    chk("R3 above", int'(state[3]), 0);
    tx_level = 16; tx_mark = 15; cyc();
    chk("R3 wide level", int'(state[3]), 0);
    tx_level = 8; tx_mark = 2;

    rx_level = 5; rx_mark = 5; cyc();
    chk("R4 equal", int'(state), 5'b00010);
    rx_level = 4; cyc();
    chk("R4 below", int'(state[1]), 0);
    rx_level = 0; rx_mark = 0; cyc();
    chk("R4 zero mark", int'(state[1]), 1);
    rx_mark = 4; cyc();

    tx_empty = 1; rx_full = 1; cyc();
    chk("R5 flags", int'(state), 5'b00101);
    wr(2'd0, 5'b00101);
    chk("R5 ack ignored", int'(state), 5'b00101);
    tx_empty = 0; rx_full = 0; cyc();
    chk("R5 release", int'(state), 0);

    done = 1; cyc(); done = 0;
    chk("R6 latch", int'(state), 5'b10000);
    cyc(); cyc(); cyc();
    chk("R7 hold", int'(state), 5'b10000);
    wr(2'd0, 5'b01111);
    chk("R7 zero ack", int'(state), 5'b10000);
    wr(2'd0, 5'b10000);
    chk("R7 cleared", int'(state), 0);
    done = 1; wr(2'd0, 5'b10000); done = 0;
    chk("R7 set wins", int'(state), 5'b10000);
    wr(2'd0, 5'b10000);
    chk("R7 cleared again", int'(state), 0);

    wr(2'd1, 5'b01000);
    chk("R8 enable", int'(enable), 5'b01000);
    chk("R10 masked", int'(irq), 0);
    tx_level = 0; cyc();
    chk("R10 irq with state", int'(irq), 1);
    tx_level = 8; cyc();
    chk("R10 irq drop", int'(irq), 0);

    wr(2'd2, 5'b01001);
    chk("R9 force", int'(state), 5'b01001);
    chk("R9 irq", int'(irq), 1);
    cyc();
    chk("R9 one update", int'(state), 0);
    wr(2'd2, 5'b10000); cyc();
    chk("R9 event latched", int'(state), 5'b10000);
    wr(2'd0, 5'b10000);

    wr(2'd3, 5'b11111);
    chk("R11 enable kept", int'(enable), 5'b01000);
    chk("R11 state kept", int'(state), 0);

    for (int i = 0; i < 400; i++) begin
      tx_level = LW'($urandom_range(0, 20));
      rx_level = LW'($urandom_range(0, 20));
      tx_mark = MW'($urandom);
      rx_mark = MW'($urandom);
      tx_empty = 1'($urandom);
      rx_full = 1'($urandom);
      done = ($urandom_range(0, 7) == 0);
      wr_en = 1'($urandom);
      wr_sel = 2'($urandom);
      wr_data = 5'($urandom);
      cyc();
    end
    wr_en = 0; done = 0;
    cyc();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule